// File: doc/BRIEF.md
# DMA Address-Match Buffer Interrupt Unit

This block watches the address stream that an audio DMA engine produces and raises an interrupt when that stream reaches one of four software-programmed buffer-level addresses. Each level has its own compare address, its own enable bit and its own sticky status flag. A flag is set on an exact address match, even when its level is disabled, so software can poll a masked level. It stays set until software writes the clear bit for that level.

Software uses a single-cycle register port to reach the block. One selector value addresses a control word that holds the enables, the status flags and the write-one-to-clear bits. Four more selector values address the four level-address registers. The interrupt output is one registered line: the OR, over all levels, of status AND enable.

Top module: `dma_level_irq`

## Requirements
- R1: Register selector 0 addresses the control word, and selectors 1 to 4 address the compare addresses of levels 0 to 3. Every other selector value reads as zero. A write takes effect at the clock edge on which reg_wr is high, and reads are combinational from reg_sel.
- R2: Each level-address register is a full 32-bit read/write register that resets to zero and reads back exactly the value last written.
- R3: In the control word, the enable of level i sits at bit 24+i and the status flag of level i at bit 20+i. Bits 19:16 are write-one-to-clear bits for levels 0 to 3 and always read as zero. Bits 31:28 and 15:0 read as zero. Writes to the status bit positions have no effect.
- R4: A level's status flag is visible in the control word one clock after a fresh DMA presentation whose address equals that level's compare address. This holds whatever the value of its enable bit. A non-matching address sets no flag.
- R5: A status flag stays set across any number of reads and idle cycles. It is cleared at the edge of a control-word write that has a 1 in that level's clear bit.
- R6: If a fresh match and a clear for the same level fall in the same cycle, the flag ends up set.
- R7: irq is a register that takes the OR over all levels of (status AND enable), one clock after those values. A level whose enable is 0 never drives irq.
- R8: A presentation is fresh when dma_valid is high and either dma_valid was low in the previous cycle or dma_addr differs from the previous cycle's address. A held address makes no new match after a clear. Cycles with dma_valid low compare nothing.
- R9: After reset, all enables, all status flags and irq are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | SEL_W (3) | Register selector |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| dma_valid | input | 1 | DMA address valid strobe |
| dma_addr | input | ADDR_W (32) | Address generated by the DMA engine |
| irq | output | 1 | Combined registered interrupt |

## Verification
The bench builds the block with its default parameters: 32-bit DMA addresses, four levels and a 3-bit selector. With these values every level-address register can hold values with the top bit set and the low bits set. All four levels are reachable, and so are the unused selector codes 5 to 7. The sequences cover held and back-to-back addresses, a clear and a match in the same cycle, and a level that is masked while its flag is set.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;
  localparam int CTRL_W      = 32;
  localparam int MAX_LVL     = 4;
  localparam int EN_LSB      = 24;
  localparam int ST_LSB      = 20;
  localparam int CLR_LSB     = 16;
  localparam int SEL_CTRL    = 0;
  localparam int SEL_LVLBASE = 1;

  // Control word image from enable and status vectors (MAX_LVL wide, zero padded)
  function automatic logic [CTRL_W-1:0] pack_ctrl(input logic [MAX_LVL-1:0] en,
                                                  input logic [MAX_LVL-1:0] st);
    logic [CTRL_W-1:0] w;
    w = '0;
    w[EN_LSB +: MAX_LVL] = en;
    w[ST_LSB +: MAX_LVL] = st;
    return w;
  endfunction

  // Next sticky flag value: a set always beats a clear
  function automatic logic [MAX_LVL-1:0] next_flags(input logic [MAX_LVL-1:0] cur,
                                                    input logic [MAX_LVL-1:0] clr,
                                                    input logic [MAX_LVL-1:0] set);
    return (cur & ~clr) | set;
  endfunction
endpackage

// File: rtl/dmairq_regs.sv
module dmairq_regs
  import dmairq_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int NUM_LVL = 4,
  parameter int SEL_W   = 3
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [SEL_W-1:0]                 reg_sel,
  input  logic                             reg_wr,
  input  logic [CTRL_W-1:0]                reg_wdata,
  input  logic [NUM_LVL-1:0]               st,
  output logic [CTRL_W-1:0]                reg_rdata,
  output logic [NUM_LVL-1:0]               en,
  output logic [NUM_LVL-1:0][ADDR_W-1:0]   lvl_addr,
  output logic [NUM_LVL-1:0]               clr_pulse
);
  logic ctrl_wr;
  logic [MAX_LVL-1:0] en_pad, st_pad;

  assign ctrl_wr   = reg_wr && (reg_sel == SEL_W'(SEL_CTRL));
  assign clr_pulse = ctrl_wr ? reg_wdata[CLR_LSB +: NUM_LVL] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       en <= '0;
    else if (ctrl_wr) en <= reg_wdata[EN_LSB +: NUM_LVL];
  end

  for (genvar i = 0; i < NUM_LVL; i++) begin : g_lvl
    logic lvl_wr;
    assign lvl_wr = reg_wr && (reg_sel == SEL_W'(SEL_LVLBASE + i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      lvl_addr[i] <= '0;
      else if (lvl_wr) lvl_addr[i] <= reg_wdata[ADDR_W-1:0];
    end
  end

  always_comb begin
    en_pad = '0;
    st_pad = '0;
    en_pad[NUM_LVL-1:0] = en;
    st_pad[NUM_LVL-1:0] = st;
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_sel == SEL_W'(SEL_CTRL)) reg_rdata = pack_ctrl(en_pad, st_pad);
    for (int i = 0; i < NUM_LVL; i++) begin
      if (reg_sel == SEL_W'(SEL_LVLBASE + i)) reg_rdata[ADDR_W-1:0] = lvl_addr[i];
    end
  end
endmodule

// File: rtl/dmairq_detect.sv
module dmairq_detect #(
  parameter int ADDR_W  = 32,
  parameter int NUM_LVL = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           dma_valid,
  input  logic [ADDR_W-1:0]              dma_addr,
  input  logic [NUM_LVL-1:0][ADDR_W-1:0] lvl_addr,
  output logic                           fresh,
  output logic [NUM_LVL-1:0]             hit
);
  logic              prev_valid;
  logic [ADDR_W-1:0] prev_addr;

  function automatic logic is_fresh(input logic v, input logic pv,
                                    input logic [ADDR_W-1:0] a,
                                    input logic [ADDR_W-1:0] pa);
    return v && (!pv || (a != pa));
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_valid <= 1'b0;
      prev_addr  <= '0;
    end else begin
      prev_valid <= dma_valid;
      if (dma_valid) prev_addr <= dma_addr;
    end
  end

  assign fresh = is_fresh(dma_valid, prev_valid, dma_addr, prev_addr);

  for (genvar i = 0; i < NUM_LVL; i++) begin : g_cmp
    assign hit[i] = fresh && (dma_addr == lvl_addr[i]);
  end
endmodule

// File: rtl/dmairq_status.sv
module dmairq_status
  import dmairq_pkg::*;
#(
  parameter int NUM_LVL = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_LVL-1:0] hit,
  input  logic [NUM_LVL-1:0] clr,
  input  logic [NUM_LVL-1:0] en,
  output logic [NUM_LVL-1:0] st,
  output logic               irq
);
  logic [MAX_LVL-1:0] cur_pad, clr_pad, hit_pad, nxt_pad;

  always_comb begin
    cur_pad = '0; clr_pad = '0; hit_pad = '0;
    cur_pad[NUM_LVL-1:0] = st;
    clr_pad[NUM_LVL-1:0] = clr;
    hit_pad[NUM_LVL-1:0] = hit;
    nxt_pad = next_flags(cur_pad, clr_pad, hit_pad);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= '0;
      irq <= 1'b0;
    end else begin
      st  <= nxt_pad[NUM_LVL-1:0];
      irq <= |(st & en);
    end
  end
endmodule

// File: rtl/dma_level_irq.sv
module dma_level_irq #(
  parameter int ADDR_W  = 32,
  parameter int NUM_LVL = 4,
  parameter int SEL_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              dma_valid,
  input  logic [ADDR_W-1:0] dma_addr,
  output logic              irq
);
  logic [NUM_LVL-1:0]             en_w, st_w, clr_w, hit_w;
  logic [NUM_LVL-1:0][ADDR_W-1:0] lvl_w;
  logic                           fresh_w;

  dmairq_regs #(.ADDR_W(ADDR_W), .NUM_LVL(NUM_LVL), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .st(st_w), .reg_rdata(reg_rdata), .en(en_w),
    .lvl_addr(lvl_w), .clr_pulse(clr_w)
  );

  dmairq_detect #(.ADDR_W(ADDR_W), .NUM_LVL(NUM_LVL)) u_det (
    .clk(clk), .rst_n(rst_n), .dma_valid(dma_valid), .dma_addr(dma_addr),
    .lvl_addr(lvl_w), .fresh(fresh_w), .hit(hit_w)
  );

  dmairq_status #(.NUM_LVL(NUM_LVL)) u_st (
    .clk(clk), .rst_n(rst_n), .hit(hit_w), .clr(clr_w), .en(en_w),
    .st(st_w), .irq(irq)
  );
endmodule

// File: rtl/dmairq_chk.sv
module dmairq_chk #(
  parameter int NUM_LVL = 4,
  parameter int SEL_W   = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               dma_valid,
  input logic [NUM_LVL-1:0] hit,
  input logic [NUM_LVL-1:0] clr,
  input logic [NUM_LVL-1:0] st,
  input logic [NUM_LVL-1:0] en,
  input logic               irq,
  input logic [SEL_W-1:0]   sel,
  input logic [31:0]        rdata
);
  a_r4_hit_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit) |=> ((st & $past(hit)) == $past(hit)));

  a_r4_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((st & ~$past(st) & ~$past(hit)) == '0));

  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((st & $past(st & ~clr)) == $past(st & ~clr)));

  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr & ~hit)) |=> ((st & $past(clr & ~hit)) == '0));

  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr & hit)) |=> ((st & $past(clr & hit)) == $past(clr & hit)));

  a_r7_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (irq == $past(|(st & en))));

  a_r8_idle_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_valid |-> (hit == '0));

  a_r3_ctrl_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == '0) |-> ((rdata[31:28] == 4'h0) && (rdata[19:0] == 20'h0)));
endmodule

bind dma_level_irq dmairq_chk #(.NUM_LVL(NUM_LVL), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .dma_valid(dma_valid), .hit(hit_w), .clr(clr_w),
  .st(st_w), .en(en_w), .irq(irq), .sel(reg_sel), .rdata(reg_rdata)
);

// File: tb/sim_dma_level_irq.sv
`timescale 1ns/1ps
module sim_dma_level_irq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        dma_valid = 1'b0;
  logic [31:0] dma_addr = '0;
  logic        irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] exp;
    bit          is_irq;
    string       req;
  } item_t;
  item_t sb[$];

  logic [3:0] m_en = '0;
  logic [3:0] m_st = '0;

  always #2.5 clk = ~clk;

  dma_level_irq u0 (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dma_valid(dma_valid),
    .dma_addr(dma_addr), .irq(irq)
  );

  // Expected control word built from the bit positions in R3
  function automatic logic [31:0] ctl(input logic [3:0] e, input logic [3:0] s);
    return {4'h0, e, s, 20'h0};
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_rd(input logic [2:0] sel, input logic [31:0] exp, input string req);
    item_t it;
    reg_sel = sel;
    it.exp = exp; it.is_irq = 1'b0; it.req = req;
    sb.push_back(it);
    step();
  endtask

  task automatic expect_irq(input logic exp, input string req);
    item_t it;
    it.exp = {31'h0, exp}; it.is_irq = 1'b1; it.req = req;
    sb.push_back(it);
    step();
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] data);
    reg_sel = sel; reg_wr = 1'b1; reg_wdata = data;
    step();
    reg_wr = 1'b0;
  endtask

  task automatic present(input logic [31:0] a);
    dma_valid = 1'b1; dma_addr = a;
    step();
    dma_valid = 1'b0;
  endtask

  // Monitor: compare queued expectations away from the active edge
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      logic [31:0] got;
      it = sb.pop_front();
      got = it.is_irq ? {31'h0, irq} : reg_rdata;
      n_cmp++;
      if (got !== it.exp) begin
        n_bad++;
        $display("FAIL %s: got %h expected %h", it.req, got, it.exp);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    step(); step();
    rst_n = 1'b1;
    step();
    // R9 reset state
    expect_rd(3'd0, 32'h0, "R9 ctrl after reset");
    expect_irq(1'b0, "R9 irq after reset");
    expect_rd(3'd1, 32'h0, "R2 level addr reset");

    // R2 program and read back level addresses
    wr(3'd1, 32'h0000_1000);
    wr(3'd2, 32'h8000_2004);
    wr(3'd3, 32'h0000_3000);
    wr(3'd4, 32'hFFFF_FFFC);
    expect_rd(3'd1, 32'h0000_1000, "R2 lvl0");
    expect_rd(3'd2, 32'h8000_2004, "R2 lvl1");
    expect_rd(3'd3, 32'h0000_3000, "R2 lvl2");
    expect_rd(3'd4, 32'hFFFF_FFFC, "R2 lvl3");
    // R1 unused selectors read zero
    expect_rd(3'd5, 32'h0, "R1 sel5");
    expect_rd(3'd7, 32'h0, "R1 sel7");

    // R3 status bits and reserved bits ignored on write
    wr(3'd0, 32'hF0F0_FFFF);
    expect_rd(3'd0, ctl(m_en, m_st), "R3 status/reserved write ignored");

    // R4 flag set while enable is 0; R7 irq masked
    present(32'h8000_2004);
    m_st = 4'b0010;
    expect_rd(3'd0, ctl(m_en, m_st), "R4 flag set with enable low");
    expect_irq(1'b0, "R7 masked level");

    // R7 enabling raises irq one cycle after enable
    wr(3'd0, 32'h0200_0000);
    m_en = 4'b0010;
    step();
    expect_irq(1'b1, "R7 irq after enable");

    // R8 held address: clear during hold, no re-set
    dma_valid = 1'b1; dma_addr = 32'h0000_3000;
    step();
    reg_sel = 3'd0; reg_wr = 1'b1; reg_wdata = {4'h0, m_en, 4'h0, 4'b0100, 16'h0};
    step();
    reg_wr = 1'b0;
    step(); step();
    dma_valid = 1'b0;
    expect_rd(3'd0, ctl(m_en, m_st), "R8 held address no re-set");
    // R8 re-presentation after a gap sets again
    present(32'h0000_3000);
    m_st = 4'b0110;
    expect_rd(3'd0, ctl(m_en, m_st), "R8 re-presented after gap");

    // R8 matching address with valid low: nothing
    dma_addr = 32'h0000_1000;
    step();
    expect_rd(3'd0, ctl(m_en, m_st), "R8 valid low no compare");
    // R4 non-matching address
    present(32'h0000_1004);
    expect_rd(3'd0, ctl(m_en, m_st), "R4 non-match no flag");

    // R6 match and clear in the same cycle
    dma_valid = 1'b1; dma_addr = 32'h0000_1000;
    reg_sel = 3'd0; reg_wr = 1'b1; reg_wdata = {4'h0, m_en, 4'h0, 4'b0001, 16'h0};
    step();
    dma_valid = 1'b0; reg_wr = 1'b0;
    m_st = 4'b0111;
    expect_rd(3'd0, ctl(m_en, m_st), "R6 set wins over clear");
    // R5 reads do not clear
    expect_rd(3'd0, ctl(m_en, m_st), "R5 sticky across read 1");
    expect_rd(3'd0, ctl(m_en, m_st), "R5 sticky across read 2");

    // R5 clear all, enables off
    wr(3'd0, 32'h000F_0000);
    m_en = 4'b0000; m_st = 4'b0000;
    expect_rd(3'd0, ctl(m_en, m_st), "R5 clear all");
    expect_irq(1'b0, "R7 irq drops after clear");

    // R8 back-to-back different addresses both fresh
    dma_valid = 1'b1; dma_addr = 32'h0000_3000;
    step();
    dma_addr = 32'hFFFF_FFFC;
    step();
    dma_valid = 1'b0;
    m_st = 4'b1100;
    expect_rd(3'd0, ctl(m_en, m_st), "R8 back-to-back addresses");

    // R7 only level 0 enabled, flags elsewhere: irq stays low
    wr(3'd0, 32'h0100_0000);
    m_en = 4'b0001;
    step();
    expect_irq(1'b0, "R7 unrelated enable");

    // R7 combined OR over levels
    wr(3'd0, 32'h0F00_0000);
    m_en = 4'b1111;
    step();
    expect_irq(1'b1, "R7 all enabled");
    wr(3'd0, 32'h0F04_0000);
    m_st = 4'b1000;
    step();
    expect_irq(1'b1, "R7 one flag left");
    wr(3'd0, 32'h0F08_0000);
    m_st = 4'b0000;
    step();
    expect_irq(1'b0, "R7 last flag cleared");
    expect_rd(3'd0, ctl(m_en, m_st), "R3 clear bits read zero");

    step(); step();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule